// File: doc/BRIEF.md
# Haar Rectangle Sum Pipeline

This block evaluates Haar-like rectangle sums against an integral-image window of WIN by WIN entries (24 by 24 by default). The integral image arrives on one wide input port that the surrounding logic holds steady while rectangles are scanned. Rectangle descriptors enter several lanes side by side (three by default). Each descriptor carries two column coordinates, two row coordinates and a signed weight.

The block is a chain of WIN column stages, numbered 1 to WIN. A descriptor moves one stage per clock and carries a running signed total that starts at zero. Stage number c looks only at column c of the window. A row selector inside the stage picks the entries in that column that the descriptor's row coordinates address. When c equals the first column coordinate, the stage adds one corner difference to the total. When c equals the second, it adds the opposite difference. After the last stage the total is the four-corner rectangle sum. Once the chain is full, every lane delivers one result on every clock. A valid flag travels with each lane, so a lane that was left empty never shows up as a result. The weight rides along unchanged for the classifier that follows.

Top module: `haar_rect_pipe`

## Requirements
- R1: The reset is synchronous and active high. While it is asserted, and on the first clock after it, every lane shows out_vld low and out_sum and out_wgt zero. Descriptors that were in flight when reset arrived never appear at the outputs.
- R2: SAT(x,y), with column x and row y both in 1..WIN, is the IIW-bit unsigned field of sat_win starting at bit ((y-1)*WIN + (x-1))*IIW.
- R3: For a valid descriptor, the output sum is SAT(x2,y2) - SAT(x2,y1) - SAT(x1,y2) + SAT(x1,y1) as a SUMW-bit two's-complement value. Stage x1 contributes +SAT(x1,y1) - SAT(x1,y2) and stage x2 contributes +SAT(x2,y2) - SAT(x2,y1). When x1 equals x2, both contributions apply, so the result is zero.
- R4: A descriptor sampled at rising edge k is visible at the outputs just after rising edge k+WIN-1, which is WIN register stages. Each lane accepts a new descriptor on every clock.
- R5: out_vld of a lane rises for exactly those descriptors that entered that lane with in_vld high. A cycle with in_vld low produces no result.
- R6: A lane whose out_vld is low shows out_sum and out_wgt as zero.
- R7: out_wgt of a valid lane equals the in_wgt bits that entered with the descriptor.
- R8: An x coordinate of 0 or above WIN matches no stage and adds nothing. A y coordinate of 0 or above WIN reads as a zero entry. Either case is the same as SAT being zero at that coordinate in R3.
- R9: The sum of a valid lane never exceeds 2*(2^IIW - 1) in magnitude.
- R10: Lanes are independent. Coordinates, valid flags and results of one lane never affect another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sat_win | input | WIN*WIN*IIW | Integral-image window, layout as in R2 |
| in_vld | input | LANES | Descriptor valid, one bit per lane |
| in_x1 | input | LANES*CW | First column coordinate per lane, unsigned, CW = clog2(WIN+1) |
| in_x2 | input | LANES*CW | Second column coordinate per lane |
| in_y1 | input | LANES*CW | First row coordinate per lane |
| in_y2 | input | LANES*CW | Second row coordinate per lane |
| in_wgt | input | LANES*WGTW | Weight per lane, carried unchanged |
| out_vld | output | LANES | Result valid per lane |
| out_sum | output | LANES*SUMW | Signed rectangle sum per lane |
| out_wgt | output | LANES*WGTW | Weight delivered with the sum |

## Verification
The bench builds the block with WIN=4, three lanes, IIW=8, SUMW=12 and WGTW=8. At that size every combination of the four coordinates over 0..5 can be swept: 1296 descriptors per window. The sweep covers reversed corners, equal columns, and coordinates outside the window on both ends. It runs against two different window images. A per-lane bubble pattern keeps the lanes out of step with each other. The four-stage chain shows the latency, the drain, and a reset that lands mid-stream within a few cycles.

// File: rtl/haar_pkg.sv
package haar_pkg;
  localparam int DEF_WIN   = 24;
  localparam int DEF_LANES = 3;
  localparam int DEF_IIW   = 18;
  localparam int DEF_SUMW  = 20;
  localparam int DEF_WGTW  = 16;

  // coordinate fields packed per lane inside the coordinate pipeline
  localparam int F_Y2  = 0;
  localparam int F_Y1  = 1;
  localparam int F_X2  = 2;
  localparam int F_X1  = 3;
  localparam int NFLD  = 4;

  // signed corner difference, sign-extended to the accumulator width
  function automatic logic signed [63:0] corner_diff(input logic [31:0] a, input logic [31:0] b);
    return $signed({32'd0, a}) - $signed({32'd0, b});
  endfunction
endpackage

// File: rtl/haar_col_mux.sv
module haar_col_mux #(
  parameter int WIN = 24,
  parameter int IIW = 18,
  parameter int CW  = 5
) (
  input  logic [WIN*IIW-1:0] col,
  input  logic [CW-1:0]      row,
  output logic [IIW-1:0]     val
);
  // rows 1..WIN map to slices 0..WIN-1; any other code reads as zero
  always_comb begin
    val = '0;
    for (int r = 1; r <= WIN; r++) begin
      if (row == CW'(r)) val = col[(r-1)*IIW +: IIW];
    end
  end
endmodule

// File: rtl/haar_cell.sv
module haar_cell
  import haar_pkg::*;
#(
  parameter int IDX   = 1,
  parameter int WIN   = 24,
  parameter int LANES = 3,
  parameter int IIW   = 18,
  parameter int SUMW  = 20,
  parameter int WGTW  = 16,
  parameter int CW    = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [WIN*IIW-1:0]       col,
  input  logic [LANES-1:0]         i_vld,
  input  logic [LANES*NFLD*CW-1:0] i_crd,
  input  logic [LANES*SUMW-1:0]    i_sum,
  input  logic [LANES*WGTW-1:0]    i_wgt,
  output logic [LANES-1:0]         o_vld,
  output logic [LANES*SUMW-1:0]    o_sum,
  output logic [LANES*WGTW-1:0]    o_wgt
);
  localparam int LW = NFLD*CW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CW-1:0]          x1, x2, y1, y2;
    logic [IIW-1:0]         v1, v2;
    logic                   hit1, hit2;
    logic signed [63:0]     dwide;
    logic signed [SUMW-1:0] dext;
    logic signed [SUMW-1:0] acc;
    logic                   vld_q;
    logic [SUMW-1:0]        sum_q;
    logic [WGTW-1:0]        wgt_q;

    assign x1 = i_crd[l*LW + F_X1*CW +: CW];
    assign x2 = i_crd[l*LW + F_X2*CW +: CW];
    assign y1 = i_crd[l*LW + F_Y1*CW +: CW];
    assign y2 = i_crd[l*LW + F_Y2*CW +: CW];

    haar_col_mux #(.WIN(WIN), .IIW(IIW), .CW(CW)) u_row1 (.col(col), .row(y1), .val(v1));
    haar_col_mux #(.WIN(WIN), .IIW(IIW), .CW(CW)) u_row2 (.col(col), .row(y2), .val(v2));

    assign hit1  = (x1 == CW'(IDX));
    assign hit2  = (x2 == CW'(IDX));
    assign dwide = corner_diff(32'(v1), 32'(v2));
    assign dext  = dwide[SUMW-1:0];

    always_comb begin
      acc = $signed(i_sum[l*SUMW +: SUMW]);
      if (hit1) acc = acc + dext;
      if (hit2) acc = acc - dext;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        sum_q <= '0;
        wgt_q <= '0;
      end else begin
        vld_q <= i_vld[l];
        sum_q <= i_vld[l] ? acc : '0;
        wgt_q <= i_vld[l] ? i_wgt[l*WGTW +: WGTW] : '0;
      end
    end

    assign o_vld[l]                = vld_q;
    assign o_sum[l*SUMW +: SUMW]   = sum_q;
    assign o_wgt[l*WGTW +: WGTW]   = wgt_q;
  end
endmodule

// File: rtl/haar_rect_pipe.sv
module haar_rect_pipe
  import haar_pkg::*;
#(
  parameter  int WIN   = DEF_WIN,
  parameter  int LANES = DEF_LANES,
  parameter  int IIW   = DEF_IIW,
  parameter  int SUMW  = DEF_SUMW,
  parameter  int WGTW  = DEF_WGTW,
  localparam int CW    = $clog2(WIN+1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WIN*WIN*IIW-1:0] sat_win,
  input  logic [LANES-1:0]       in_vld,
  input  logic [LANES*CW-1:0]    in_x1,
  input  logic [LANES*CW-1:0]    in_x2,
  input  logic [LANES*CW-1:0]    in_y1,
  input  logic [LANES*CW-1:0]    in_y2,
  input  logic [LANES*WGTW-1:0]  in_wgt,
  output logic [LANES-1:0]       out_vld,
  output logic [LANES*SUMW-1:0]  out_sum,
  output logic [LANES*WGTW-1:0]  out_wgt
);
  localparam int LW = NFLD*CW;
  localparam int BW = LANES*LW;

  // column slices of the window, one per stage
  logic [WIN*IIW-1:0] col_s [WIN];
  for (genvar c = 0; c < WIN; c++) begin : g_col
    for (genvar r = 0; r < WIN; r++) begin : g_row
      assign col_s[c][r*IIW +: IIW] = sat_win[(r*WIN + c)*IIW +: IIW];
    end
  end

  // coordinate delay line: stage k feeds cell k+1
  logic [BW-1:0] crd_s [WIN];
  for (genvar l = 0; l < LANES; l++) begin : g_pack
    assign crd_s[0][l*LW + F_X1*CW +: CW] = in_x1[l*CW +: CW];
    assign crd_s[0][l*LW + F_X2*CW +: CW] = in_x2[l*CW +: CW];
    assign crd_s[0][l*LW + F_Y1*CW +: CW] = in_y1[l*CW +: CW];
    assign crd_s[0][l*LW + F_Y2*CW +: CW] = in_y2[l*CW +: CW];
  end
  for (genvar k = 1; k < WIN; k++) begin : g_crd
    logic [BW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= crd_s[k-1];
    end
    assign crd_s[k] = q;
  end

  // valid, running sum and weight chain
  logic [LANES-1:0]      vld_s [WIN+1];
  logic [LANES*SUMW-1:0] sum_s [WIN+1];
  logic [LANES*WGTW-1:0] wgt_s [WIN+1];

  assign vld_s[0] = in_vld;
  assign sum_s[0] = '0;
  assign wgt_s[0] = in_wgt;

  for (genvar k = 1; k <= WIN; k++) begin : g_cell
    haar_cell #(
      .IDX(k), .WIN(WIN), .LANES(LANES), .IIW(IIW),
      .SUMW(SUMW), .WGTW(WGTW), .CW(CW)
    ) u_cell (
      .clk  (clk),
      .rst  (rst),
      .col  (col_s[k-1]),
      .i_vld(vld_s[k-1]),
      .i_crd(crd_s[k-1]),
      .i_sum(sum_s[k-1]),
      .i_wgt(wgt_s[k-1]),
      .o_vld(vld_s[k]),
      .o_sum(sum_s[k]),
      .o_wgt(wgt_s[k])
    );
  end

  assign out_vld = vld_s[WIN];
  assign out_sum = sum_s[WIN];
  assign out_wgt = wgt_s[WIN];
endmodule

// File: rtl/haar_rect_pipe_chk.sv
module haar_rect_pipe_chk #(
  parameter int WIN   = 24,
  parameter int LANES = 3,
  parameter int IIW   = 18,
  parameter int SUMW  = 20
) (
  input logic                  clk,
  input logic                  rst,
  input logic [LANES-1:0]      in_vld,
  input logic [LANES-1:0]      out_vld,
  input logic [LANES*SUMW-1:0] out_sum
);
  localparam int OW   = $clog2(WIN+2) + 1;
  localparam int MAXV = 2*((1 << IIW) - 1);

  // R1: reset leaves no result behind
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (out_vld == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [OW-1:0]          pend;
    logic signed [SUMW-1:0] s;
    assign s = out_sum[l*SUMW +: SUMW];

    always_ff @(posedge clk) begin
      if (rst) pend <= '0;
      else     pend <= pend + OW'(in_vld[l]) - OW'(out_vld[l]);
    end

    // R5: a result needs a descriptor that entered this lane
    a_r5_no_orphan: assert property (@(posedge clk) disable iff (rst)
      out_vld[l] |-> (pend != '0));
    // R4: no more than WIN descriptors in flight per lane
    a_r4_depth: assert property (@(posedge clk) disable iff (rst)
      pend <= OW'(WIN));
    // R6: an empty lane shows a zero sum
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !out_vld[l] |-> (s == '0));
    // R9: magnitude bound of a valid sum
    a_r9_bound: assert property (@(posedge clk) disable iff (rst)
      out_vld[l] |-> ((int'(s) <= MAXV) && (int'(s) >= -MAXV)));
  end
endmodule

bind haar_rect_pipe haar_rect_pipe_chk #(
  .WIN(WIN), .LANES(LANES), .IIW(IIW), .SUMW(SUMW)
) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .out_vld(out_vld), .out_sum(out_sum)
);

// File: tb/test_haar_rect_pipe.sv
`timescale 1ns/1ps
module test_haar_rect_pipe;
  localparam int WIN   = 4;
  localparam int LANES = 3;
  localparam int IIW   = 8;
  localparam int SUMW  = 12;
  localparam int WGTW  = 8;
  localparam int CW    = $clog2(WIN+1);
  localparam int NC    = WIN + 2;          // coordinates 0..WIN+1
  localparam int NR    = NC*NC*NC*NC;
  localparam int MAXS  = 1024;
  localparam int MAXV  = 2*((1 << IIW) - 1);

  logic                   clk = 1'b0;
  logic                   rst;
  logic [WIN*WIN*IIW-1:0] sat_win;
  logic [LANES-1:0]       in_vld;
  logic [LANES*CW-1:0]    in_x1, in_x2, in_y1, in_y2;
  logic [LANES*WGTW-1:0]  in_wgt;
  logic [LANES-1:0]       out_vld;
  logic [LANES*SUMW-1:0]  out_sum;
  logic [LANES*WGTW-1:0]  out_wgt;

  always #2.5 clk = ~clk;

  haar_rect_pipe #(
    .WIN(WIN), .LANES(LANES), .IIW(IIW), .SUMW(SUMW), .WGTW(WGTW)
  ) i_haar_rect_pipe (
    .clk(clk), .rst(rst), .sat_win(sat_win), .in_vld(in_vld),
    .in_x1(in_x1), .in_x2(in_x2), .in_y1(in_y1), .in_y2(in_y2), .in_wgt(in_wgt),
    .out_vld(out_vld), .out_sum(out_sum), .out_wgt(out_wgt)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int sat_t [WIN+1][WIN+1];
  int exp_v [MAXS][LANES];
  int exp_s [MAXS][LANES];
  int exp_w [MAXS][LANES];
  int exp_o [MAXS][LANES];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int satv(input int x, input int y);
    if (x < 1 || x > WIN || y < 1 || y > WIN) return 0;
    return sat_t[x][y];
  endfunction

  task automatic load_window(input int seed);
    for (int x = 0; x <= WIN; x++) sat_t[x][0] = 0;
    for (int y = 0; y <= WIN; y++) sat_t[0][y] = 0;
    for (int x = 1; x <= WIN; x++)
      for (int y = 1; y <= WIN; y++)
        sat_t[x][y] = ((x*7 + y*13 + seed*5 + x*y*seed) % 16)
                      + sat_t[x-1][y] + sat_t[x][y-1] - sat_t[x-1][y-1];
    for (int x = 1; x <= WIN; x++)
      for (int y = 1; y <= WIN; y++)
        sat_win[((y-1)*WIN + (x-1))*IIW +: IIW] = IIW'(sat_t[x][y]);
  endtask

  task automatic drive_idle();
    in_vld = '0; in_x1 = '0; in_x2 = '0; in_y1 = '0; in_y2 = '0; in_wgt = '0;
  endtask

  task automatic check_idle(input string req);
    for (int l = 0; l < LANES; l++) begin
      chk(out_vld[l] == 1'b0, req, int'(out_vld[l]), 0);
      chk(out_sum[l*SUMW +: SUMW] == '0 && out_wgt[l*WGTW +: WGTW] == '0, req,
          int'($signed(out_sum[l*SUMW +: SUMW])), 0);
    end
  endtask

  task automatic run_sweep(input int seed);
    int n = 0;
    int last = -1;
    int s = 0;
    load_window(seed);
    while (1) begin
      @(negedge clk);
      if (s < WIN) begin
        check_idle("R5 drained");
      end else begin
        int e = (s - WIN) % MAXS;
        for (int l = 0; l < LANES; l++) begin
          int act = int'($signed(out_sum[l*SUMW +: SUMW]));
          int aw  = int'(out_wgt[l*WGTW +: WGTW]);
          chk(int'(out_vld[l]) == exp_v[e][l], "R5 R10 valid", int'(out_vld[l]), exp_v[e][l]);
          if (exp_v[e][l] != 0) begin
            if (exp_o[e][l] != 0) chk(act == exp_s[e][l], "R8 R3 R4", act, exp_s[e][l]);
            else                  chk(act == exp_s[e][l], "R2 R3 R4", act, exp_s[e][l]);
            chk(aw == exp_w[e][l], "R7 weight", aw, exp_w[e][l]);
            chk(act <= MAXV && act >= -MAXV, "R9 bound", act, MAXV);
          end else begin
            chk(act == 0 && aw == 0, "R6 idle zero", act, 0);
          end
        end
      end
      if (n >= NR && s >= last + WIN) break;
      for (int l = 0; l < LANES; l++) begin
        int e = s % MAXS;
        if (n < NR && ((s + l) % 5) != 4) begin
          int x1 = n % NC;
          int x2 = (n / NC) % NC;
          int y1 = (n / (NC*NC)) % NC;
          int y2 = n / (NC*NC*NC);
          in_vld[l] = 1'b1;
          in_x1[l*CW +: CW] = CW'(x1);
          in_x2[l*CW +: CW] = CW'(x2);
          in_y1[l*CW +: CW] = CW'(y1);
          in_y2[l*CW +: CW] = CW'(y2);
          in_wgt[l*WGTW +: WGTW] = WGTW'(n*37 + l*11);
          exp_v[e][l] = 1;
          exp_s[e][l] = satv(x2,y2) - satv(x2,y1) - satv(x1,y2) + satv(x1,y1);
          exp_w[e][l] = (n*37 + l*11) % (1 << WGTW);
          exp_o[e][l] = (x1 == 0 || x1 > WIN || x2 == 0 || x2 > WIN ||
                         y1 == 0 || y1 > WIN || y2 == 0 || y2 > WIN) ? 1 : 0;
          n++;
          last = s;
        end else begin
          in_vld[l] = 1'b0;
          in_x1[l*CW +: CW] = '0; in_x2[l*CW +: CW] = '0;
          in_y1[l*CW +: CW] = '0; in_y2[l*CW +: CW] = '0;
          in_wgt[l*WGTW +: WGTW] = '0;
          exp_v[e][l] = 0; exp_s[e][l] = 0; exp_w[e][l] = 0; exp_o[e][l] = 0;
        end
      end
      s++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    load_window(1);
    in_vld = '1; in_x1 = '1; in_x2 = '0; in_y1 = '1; in_y2 = '0; in_wgt = '1;
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst = 1'b0;
    drive_idle();
    repeat (WIN + 1) @(negedge clk);
    check_idle("R1 after reset");

    // descriptors in flight when reset arrives are dropped
    in_vld = '1; in_x1 = '1; in_x2 = '1; in_y1 = '1; in_y2 = '1; in_wgt = '1;
    for (int l = 0; l < LANES; l++) begin
      in_x1[l*CW +: CW] = CW'(1); in_x2[l*CW +: CW] = CW'(WIN);
      in_y1[l*CW +: CW] = CW'(1); in_y2[l*CW +: CW] = CW'(WIN);
    end
    repeat (2) @(negedge clk);
    drive_idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < WIN + 1; k++) begin
      @(negedge clk);
      check_idle("R1 midstream");
    end

    run_sweep(1);
    run_sweep(3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule